// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterized set of external interrupt lines (a multiple of eight) and turns them into one interrupt request per processor context. Each line has its own sense configuration (active level or edge, which polarity, and an option to catch both edges), an enable bit, a pending bit and a route naming the single context that it interrupts. Software reaches all of this through one 32-bit word-addressed register port with single-cycle writes and a combinational read path.

Line inputs pass through a two-stage synchronizer. Level-sensed lines show their pending state live. Edge-sensed lines latch it. A single edge-control register lets software inject a pending interrupt (a software interrupt) or acknowledge a latched edge. A context's request is raised whenever any line routed to it is both pending and enabled.

Top module: `shint_ctrl`

## Requirements
- R1: A read of word address 0x000 returns the line count as (N_LINES/8 - 1) in bits [7:0] and (N_CTX - 1) in bits [15:8], with all other bits zero.
- R2: After reset every line is level-sensed, active high and disabled. The polarity words (0x040 + w) read ones for every implemented line, the trigger words (0x080 + w), dual-edge words (0x0C0 + w) and enable words (0x100 + w) read zero, and every context request is low.
- R3: A line whose trigger bit is 0 is level-sensed. Its pending bit (words 0x1C0 + w, line i in word i/32, bit i%32) is 1 exactly while the synchronized input equals its polarity bit (1 = active high, 0 = active low). The pending bit follows the input within four clock cycles and falls when the input goes inactive.
- R4: A line whose trigger bit is 1 and dual-edge bit is 0 latches pending on a rising input edge when polarity is 1, or on a falling edge when polarity is 0. The opposite edge does not set the bit and does not clear it.
- R5: When both the trigger and dual-edge bits of a line are 1, either input edge latches pending and the polarity bit has no effect.
- R6: Writing a one to a bit of the enable-set words (0x140 + w) enables that line. Writing a one to a bit of the enable-clear words (0x180 + w) disables it. Zero bits leave the enable unchanged. The enable state reads back at 0x100 + w.
- R7: A write to 0x001 with bit 31 = 1 makes the line numbered in the low $clog2(N_LINES) bits pending in any mode. A write with bit 31 = 0 clears that line's latched pending state.
- R8: If an acknowledge write to 0x001 and a new qualifying edge on the same line occur in the same cycle, the line stays pending.
- R9: Each line routes to exactly one context, held at word 0x200 + line in the low bits and reset to context 0. Context c's request is high exactly when some line routed to c is both pending and enabled.
- R10: The pending bit of a line reads as 1 even while the line is disabled, and a disabled line never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 10 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr (combinational) |
| line_in | input | N_LINES | Asynchronous external interrupt lines |
| ctx_irq | output | N_CTX | Interrupt request, one per context |

## Verification
The bound checker checks on every cycle that a request is never raised without an enabled pending line behind it, that enable-set and enable-clear writes take effect on the next cycle, that an injection write leaves the line pending, and that requests are quiet right after reset. The bench's scenarios are the only evidence for the sense behaviour: level tracking in both polarities, single-edge selection by polarity, dual-edge override and latch retention. They also cover the same-cycle acknowledge-versus-edge race, readback of configuration and routes, and the steering of a request to the second context.

// File: rtl/shint_pkg.sv
`timescale 1ns/1ps
// Package: shared address map of the shared interrupt source controller.
// Assumes a 10-bit word address. Bit 9 set selects the per-line route
// words; otherwise bits [9:6] pick a bank and bits [5:0] a word in it.
package shint_pkg;
    localparam int ADDR_W = 10;

    localparam logic [3:0] BANK_CTRL  = 4'h0;
    localparam logic [3:0] BANK_POL   = 4'h1;
    localparam logic [3:0] BANK_TRIG  = 4'h2;
    localparam logic [3:0] BANK_DUAL  = 4'h3;
    localparam logic [3:0] BANK_MASK  = 4'h4;
    localparam logic [3:0] BANK_SMASK = 4'h5;
    localparam logic [3:0] BANK_RMASK = 4'h6;
    localparam logic [3:0] BANK_PEND  = 4'h7;

    localparam logic [5:0] OFF_CFG  = 6'd0;
    localparam logic [5:0] OFF_EDGE = 6'd1;

    localparam int EDGE_SET_BIT = 31;
endpackage

// File: rtl/shint_sense.sv
`timescale 1ns/1ps
// Module: shint_sense
// Synchronizes every line through two flops, keeps one more stage for
// edge detection, and reports per line whether the level is active or a
// qualifying edge was seen this cycle. Assumes line_in is asynchronous.
module shint_sense #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] pol,
    input  logic [N_LINES-1:0] trig,
    input  logic [N_LINES-1:0] dual,
    output logic [N_LINES-1:0] level_act,
    output logic [N_LINES-1:0] edge_hit
);
    logic [N_LINES-1:0] meta_q, stab_q, prev_q;
    logic [N_LINES-1:0] rise, fall;

    // Two-flop synchronizer plus the previous-sample stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= line_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    // Edge qualification by polarity, or both edges in dual mode.
    always_comb begin
        rise      = stab_q & ~prev_q;
        fall      = ~stab_q & prev_q;
        edge_hit  = trig & ((dual & (rise | fall)) |
                            (~dual & pol & rise) |
                            (~dual & ~pol & fall));
        level_act = ~trig & ~(stab_q ^ pol);
    end
endmodule

// File: rtl/shint_route_or.sv
`timescale 1ns/1ps
// Module: shint_route_or
// Forms each context's request as the OR over lines that are active
// (pending and enabled) and routed to that context. Assumes each line
// carries one context index of CTX_W bits in route_flat.
module shint_route_or #(
    parameter int N_LINES = 32,
    parameter int N_CTX   = 2,
    parameter int CTX_W   = 1
) (
    input  logic [N_LINES-1:0]       act,
    input  logic [N_LINES*CTX_W-1:0] route_flat,
    output logic [N_CTX-1:0]         irq
);
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic hit;
        // Reduce all lines routed to context c.
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < N_LINES; i++) begin
                if (act[i] && route_flat[i*CTX_W +: CTX_W] == CTX_W'(c)) hit = 1'b1;
            end
        end
        assign irq[c] = hit;
    end
endmodule

// File: rtl/shint_ctrl.sv
`timescale 1ns/1ps
// Module: shint_ctrl (top)
// Register-mapped controller for N_LINES shared interrupt lines with
// per-line sense configuration, enable, pending latch and single-context
// route. Assumes N_LINES is a multiple of 8 (at most 512) and N_CTX >= 1.
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_CTX   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [N_LINES-1:0] line_in,
    output logic [N_CTX-1:0]   ctx_irq
);
    localparam int WORDS  = (N_LINES + 31) / 32;
    localparam int PAD_W  = WORDS * 32;
    localparam int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1;
    localparam int LINE_W = $clog2(N_LINES);
    localparam logic [7:0] CFG_LINES = 8'(N_LINES / 8 - 1);
    localparam logic [7:0] CFG_CTX   = 8'(N_CTX - 1);

    logic [3:0] bank;
    logic [5:0] off;
    logic       is_route, edge_wr, edge_set;
    logic [N_LINES-1:0] pol_q, trig_q, dual_q, mask_q, latch_q;
    logic [N_LINES-1:0] level_act, edge_hit, pend_w;
    logic [N_LINES*CTX_W-1:0] route_flat;
    logic [PAD_W-1:0] pol_pad, trig_pad, dual_pad, mask_pad, pend_pad;

    assign bank     = addr[9:6];
    assign off      = addr[5:0];
    assign is_route = addr[9];
    assign edge_wr  = wr_en && !is_route && bank == BANK_CTRL && off == OFF_EDGE;
    assign edge_set = wdata[EDGE_SET_BIT];

    shint_sense #(.N_LINES(N_LINES)) sense_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .pol(pol_q), .trig(trig_q), .dual(dual_q),
        .level_act(level_act), .edge_hit(edge_hit)
    );

    assign pend_w = latch_q | level_act;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int W = i / 32;
        localparam int B = i % 32;
        logic pol_r, trig_r, dual_r, mask_r, latch_r;
        logic [CTX_W-1:0] route_r;
        logic word_hit, line_sel;

        assign word_hit = wr_en && !is_route && off == 6'(W);
        assign line_sel = wdata[LINE_W-1:0] == LINE_W'(i);

        // Sense configuration bits, written whole-word per bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol_r  <= 1'b1;
                trig_r <= 1'b0;
                dual_r <= 1'b0;
            end else if (word_hit) begin
                if (bank == BANK_POL)  pol_r  <= wdata[B];
                if (bank == BANK_TRIG) trig_r <= wdata[B];
                if (bank == BANK_DUAL) dual_r <= wdata[B];
            end
        end

        // Enable bit: changed only by set-one and clear-one words.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      mask_r <= 1'b0;
            else if (word_hit && bank == BANK_SMASK && wdata[B]) mask_r <= 1'b1;
            else if (word_hit && bank == BANK_RMASK && wdata[B]) mask_r <= 1'b0;
        end

        // Pending latch: edge or injection wins over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   latch_r <= 1'b0;
            else if (edge_hit[i] || (edge_wr && edge_set && line_sel))  latch_r <= 1'b1;
            else if (edge_wr && !edge_set && line_sel)    latch_r <= 1'b0;
        end

        // Route to a single context.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      route_r <= '0;
            else if (wr_en && is_route && addr[8:0] == 9'(i)) route_r <= wdata[CTX_W-1:0];
        end

        assign pol_q[i]   = pol_r;
        assign trig_q[i]  = trig_r;
        assign dual_q[i]  = dual_r;
        assign mask_q[i]  = mask_r;
        assign latch_q[i] = latch_r;
        assign route_flat[i*CTX_W +: CTX_W] = route_r;
    end

    shint_route_or #(.N_LINES(N_LINES), .N_CTX(N_CTX), .CTX_W(CTX_W)) route_or_i (
        .act(pend_w & mask_q), .route_flat(route_flat), .irq(ctx_irq)
    );

    assign pol_pad  = PAD_W'(pol_q);
    assign trig_pad = PAD_W'(trig_q);
    assign dual_pad = PAD_W'(dual_q);
    assign mask_pad = PAD_W'(mask_q);
    assign pend_pad = PAD_W'(pend_w);

    // Read mux: control word, bit-packed banks, or a route word.
    always_comb begin
        int widx;
        int ridx;
        rdata = '0;
        widx  = int'(off);
        ridx  = int'(addr[8:0]);
        if (is_route) begin
            if (ridx < N_LINES) rdata = 32'(route_flat[ridx*CTX_W +: CTX_W]);
        end else if (bank == BANK_CTRL) begin
            if (off == OFF_CFG) rdata = {16'h0, CFG_CTX, CFG_LINES};
        end else if (widx < WORDS) begin
            case (bank)
                BANK_POL:  rdata = pol_pad[widx*32 +: 32];
                BANK_TRIG: rdata = trig_pad[widx*32 +: 32];
                BANK_DUAL: rdata = dual_pad[widx*32 +: 32];
                BANK_MASK: rdata = mask_pad[widx*32 +: 32];
                BANK_PEND: rdata = pend_pad[widx*32 +: 32];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/shint_ctrl_chk.sv
`timescale 1ns/1ps
// Module: shint_ctrl_chk
// Cycle-level checks of the controller, bound into every shint_ctrl.
// Assumes the bound signals keep their names in the top module.
module shint_ctrl_chk
    import shint_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_CTX   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        wdata,
    input logic [N_CTX-1:0]   ctx_irq,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] pend_w
);
    localparam int LINE_W = $clog2(N_LINES);
    localparam logic [ADDR_W-1:0] A_SMASK0 = {BANK_SMASK, 6'd0};
    localparam logic [ADDR_W-1:0] A_RMASK0 = {BANK_RMASK, 6'd0};
    localparam logic [ADDR_W-1:0] A_EDGE   = {BANK_CTRL, OFF_EDGE};

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctx_irq == '0);

    p_set_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SMASK0 && wdata[0]) |=> mask_q[0]);

    p_clear_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RMASK0 && wdata[0]) |=> !mask_q[0]);

    p_inject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EDGE && wdata[EDGE_SET_BIT] && wdata[LINE_W-1:0] == '0) |=> pend_w[0]);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_irq != '0) |-> ((pend_w & mask_q) != '0));
endmodule

bind shint_ctrl shint_ctrl_chk #(.N_LINES(N_LINES), .N_CTX(N_CTX)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctx_irq(ctx_irq), .mask_q(mask_q), .pend_w(pend_w)
);

// File: tb/shint_ctrl_tb_top.sv
`timescale 1ns/1ps
module shint_ctrl_tb_top;
    localparam int N_LINES = 32;
    localparam int N_CTX   = 2;
    localparam logic [9:0] A_CFG = 10'h000, A_EDGE = 10'h001, A_POL = 10'h040,
        A_TRIG = 10'h080, A_DUAL = 10'h0C0, A_MASK = 10'h100, A_SMASK = 10'h140,
        A_RMASK = 10'h180, A_PEND = 10'h1C0, A_ROUTE = 10'h200;
    // Level-sense vectors for line 3: {polarity, input, expected pending}.
    localparam logic [2:0] LVL_TAB [6] = '{3'b100, 3'b111, 3'b100, 3'b001, 3'b010, 3'b001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [9:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N_LINES-1:0] line_in = '0;
    logic [N_CTX-1:0] ctx_irq;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] v;

    always #10 clk = ~clk;

    shint_ctrl #(.N_LINES(N_LINES), .N_CTX(N_CTX)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .line_in(line_in), .ctx_irq(ctx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic drive(input int k, input logic val);
        @(negedge clk); line_in[k] = val;
        repeat (4) @(posedge clk);
    endtask

    task automatic pend_bit(input int k, input string req, input logic exp);
        logic [31:0] p;
        rd(A_PEND, p);
        chk(req, 32'(p[k]), 32'(exp));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R2: configuration and reset state.
        rd(A_CFG, v);  chk("R1 cfg", v, 32'h0000_0103);
        rd(A_POL, v);  chk("R2 pol reset", v, 32'hFFFF_FFFF);
        rd(A_TRIG, v); chk("R2 trig reset", v, 32'h0);
        rd(A_DUAL, v); chk("R2 dual reset", v, 32'h0);
        rd(A_MASK, v); chk("R2 mask reset", v, 32'h0);
        chk("R2 irq reset", 32'(ctx_irq), 32'h0);

        // R3: level-sense table on line 3, enabled and routed to context 0.
        wr(A_SMASK, 32'h8);
        for (int k = 0; k < 6; k++) begin
            wr(A_POL, LVL_TAB[k][2] ? 32'hFFFF_FFFF : 32'hFFFF_FFF7);
            drive(3, LVL_TAB[k][1]);
            pend_bit(3, "R3 level pending", LVL_TAB[k][0]);
            chk("R9 level irq ctx0", 32'(ctx_irq), {31'h0, LVL_TAB[k][0]});
        end
        wr(A_POL, 32'hFFFF_FFFF);
        pend_bit(3, "R3 back to inactive", 1'b0);

        // R4: single-edge on line 4.
        wr(A_TRIG, 32'h10);
        drive(4, 1'b1); pend_bit(4, "R4 rising latched", 1'b1);
        drive(4, 1'b0); pend_bit(4, "R4 held after fall", 1'b1);
        wr(A_EDGE, 32'd4); pend_bit(4, "R7 acknowledge", 1'b0);
        wr(A_POL, 32'hFFFF_FFEF);
        drive(4, 1'b1); pend_bit(4, "R4 rising ignored when pol=0", 1'b0);
        drive(4, 1'b0); pend_bit(4, "R4 falling latched when pol=0", 1'b1);
        wr(A_EDGE, 32'd4);

        // R5: dual edge ignores polarity (pol still 0 on line 4).
        wr(A_DUAL, 32'h10);
        drive(4, 1'b1); pend_bit(4, "R5 dual rising", 1'b1);
        wr(A_EDGE, 32'd4); pend_bit(4, "R5 acknowledged", 1'b0);
        drive(4, 1'b0); pend_bit(4, "R5 dual falling", 1'b1);
        wr(A_EDGE, 32'd4);

        // R8: acknowledge and new edge in the same cycle.
        @(negedge clk); line_in[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; addr = A_EDGE; wdata = 32'd4;
        @(posedge clk); #1; wr_en = 1'b0;
        pend_bit(4, "R8 edge beats acknowledge", 1'b1);
        wr(A_EDGE, 32'd4); pend_bit(4, "R8 later acknowledge", 1'b0);

        // R7 / R10: injection on a disabled level line.
        wr(A_EDGE, 32'h8000_0009);
        pend_bit(9, "R7 inject pending", 1'b1);
        chk("R10 disabled no irq", 32'(ctx_irq), 32'h0);
        wr(A_EDGE, 32'd9); pend_bit(9, "R7 inject cleared", 1'b0);

        // R6: set/clear enable, zero bits unchanged.
        wr(A_SMASK, 32'h600); rd(A_MASK, v); chk("R6 set", v, 32'h608);
        wr(A_RMASK, 32'h200); rd(A_MASK, v); chk("R6 clear", v, 32'h408);
        wr(A_SMASK, 32'h0);   rd(A_MASK, v); chk("R6 zero set", v, 32'h408);
        wr(A_RMASK, 32'h0);   rd(A_MASK, v); chk("R6 zero clear", v, 32'h408);

        // R9: route line 9 to context 1.
        rd(A_ROUTE + 10'd9, v); chk("R9 route reset", v, 32'h0);
        wr(A_ROUTE + 10'd9, 32'h1); rd(A_ROUTE + 10'd9, v); chk("R9 route readback", v, 32'h1);
        wr(A_SMASK, 32'h200);
        wr(A_EDGE, 32'h8000_0009);
        @(negedge clk); #1; chk("R9 ctx1 only", 32'(ctx_irq), 32'h2);
        wr(A_EDGE, 32'd9);
        @(negedge clk); #1; chk("R9 ctx1 released", 32'(ctx_irq), 32'h0);

        summary();
    end
endmodule